// File: doc/BRIEF.md
# Synthesizer Enhancement Control Register

This block holds an 8-bit control word for an integer-N frequency synthesizer core. Software or a configuration controller shifts the word in over a three-wire serial port: a data line, a shift clock and a write strobe. A separate enable selects this register. The serial lines are sampled in the core clock domain. Each rising edge of the shift clock pushes one data bit into a staging shifter, most significant bit first. A rising edge of the write strobe copies the staged word into the register, but only while the enable is high.

The word drives three active-high controls. The first powers the core down. The second makes counter programming take effect at once and continuously. The third routes the RF input around the dual-modulus prescaler. The word also chooses which internal observation signal appears on a single digital test pin. The choices are the feedback counter output, the prescaler modulus-select line and the reference counter output.

Selecting more than one observation source at once is a misuse. In that case the pin follows a fixed priority, and a sticky flag records the misuse until reset. Power down silences the observation pin and the counter-load control. The serial port stays fully usable during power down, so the core can be woken up again by a new write.

Top module: `pll_enh_ctrl`

## Requirements
- R1: After an asynchronous reset, every register bit and the sticky flag read 0. All outputs are then low.
- R2: Serial bits enter MSB first on rising shift-clock edges. On the write-strobe rise, bit 7 drives `pre_bypass_o`, bit 4 drives `cnt_load_o` and bit 3 drives `pwr_dn_o`.
- R3: A write-strobe rise while the enable is low leaves the register and all outputs unchanged.
- R4: Bits 0 and 1 are reserved. Values written there have no effect on any output.
- R5: With only bit 2 of the output-select bits set, `test_o` follows `fb_div_i`.
- R6: With only bit 5 of the output-select bits set, `test_o` follows `mod_sel_i`.
- R7: With only bit 6 of the output-select bits set, `test_o` follows `ref_div_i`.
- R8: With none of bits 2, 5 and 6 set, `test_o` is low.
- R9: With several of bits 2, 5 and 6 set, `test_o` follows the source with the highest priority (bit 2, then bit 5, then bit 6). `sel_err_o` rises one cycle after such a word loads.
- R10: While bit 3 is set, `test_o` and `cnt_load_o` are low. The register still accepts writes.
- R11: `sel_err_o` stays high until reset, even after a clean word is loaded.
- R12: Shift-clock edges without a write-strobe rise leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial data |
| sclk_i | input | 1 | Serial shift clock |
| swr_i | input | 1 | Serial write strobe |
| sen_i | input | 1 | Register select enable |
| fb_div_i | input | 1 | Feedback counter output |
| mod_sel_i | input | 1 | Prescaler modulus-select line |
| ref_div_i | input | 1 | Reference counter output |
| pwr_dn_o | output | 1 | Power-down control |
| cnt_load_o | output | 1 | Immediate counter-load control |
| pre_bypass_o | output | 1 | Prescaler bypass control |
| test_o | output | 1 | Selected observation signal |
| sel_err_o | output | 1 | Sticky multiple-select flag |

## Verification
The assertions run on every cycle. They check that a strobe without the enable never moves the register, and that reserved bits never hold a 1. They also check that the test pin is low when no source is chosen or power is down, that a lone select passes its source through, and that a multi-select load raises the flag, which then never falls. Only the bench scenarios can show the bit order of the serial word and the priority among sources. The same goes for the recovery from power down by a fresh write, and the return of the flag to 0 on reset. Those cases need whole serial transfers compared against an independent model.

// File: rtl/pll_enh_pkg.sv
package pll_enh_pkg;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned B_RSV0   = 0;
  localparam int unsigned B_RSV1   = 1;
  localparam int unsigned B_TAP_FB = 2;
  localparam int unsigned B_PWR    = 3;
  localparam int unsigned B_LOAD   = 4;
  localparam int unsigned B_TAP_MS = 5;
  localparam int unsigned B_TAP_RF = 6;
  localparam int unsigned B_BYP    = 7;
  localparam int unsigned N_TAP    = 3;

  localparam logic [CTRL_W-1:0] RSV_MASK =
    CTRL_W'((1 << B_RSV0) | (1 << B_RSV1));

  typedef struct packed {
    logic rf;
    logic ms;
    logic fb;
  } tap_sel_t;
endpackage

// File: rtl/pll_enh_sync.sv
module pll_enh_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pll_enh_sif.sv
module pll_enh_sif
  import pll_enh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              sclk_i,
  input  logic              swr_i,
  input  logic              sen_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              load_o
);
  logic              sclk_d, swr_d;
  logic              sclk_rise, wr_rise;
  logic [CTRL_W-1:0] shift_q, ctrl_q;

  assign sclk_rise = sclk_i & ~sclk_d;
  assign wr_rise   = swr_i & ~swr_d;
  assign load_o    = wr_rise & sen_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d  <= 1'b0;
      swr_d   <= 1'b0;
      shift_q <= '0;
    end else begin
      sclk_d <= sclk_i;
      swr_d  <= swr_i;
      if (sclk_rise) shift_q <= {shift_q[CTRL_W-2:0], sdata_i};
    end
  end

  // reserved positions are never stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctrl_q <= '0;
    else if (load_o) ctrl_q <= shift_q & ~RSV_MASK;
  end

  assign ctrl_o = ctrl_q;

  p_no_load_wo_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_rise && sen_i) |=> $stable(ctrl_q));
endmodule

// File: rtl/pll_enh_tap.sv
module pll_enh_tap
  import pll_enh_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  tap_sel_t sel_i,
  input  logic     pwr_dn_i,
  input  logic     fb_i,
  input  logic     ms_i,
  input  logic     rf_i,
  output logic     tap_o,
  output logic     multi_o
);
  logic raw;

  always_comb begin
    if      (sel_i.fb) raw = fb_i;
    else if (sel_i.ms) raw = ms_i;
    else if (sel_i.rf) raw = rf_i;
    else               raw = 1'b0;
  end

  assign tap_o   = raw & ~pwr_dn_i;
  assign multi_o = ($countones(sel_i) > 1);

  p_no_src_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |-> !tap_o);
  p_fb_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i.fb && !pwr_dn_i) |-> (tap_o == fb_i));
  p_ms_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b010 && !pwr_dn_i) |-> (tap_o == ms_i));
  p_rf_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b100 && !pwr_dn_i) |-> (tap_o == rf_i));
endmodule

// File: rtl/pll_enh_ctrl.sv
module pll_enh_ctrl
  import pll_enh_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sdata_i,
  input  logic sclk_i,
  input  logic swr_i,
  input  logic sen_i,
  input  logic fb_div_i,
  input  logic mod_sel_i,
  input  logic ref_div_i,
  output logic pwr_dn_o,
  output logic cnt_load_o,
  output logic pre_bypass_o,
  output logic test_o,
  output logic sel_err_o
);
  localparam int unsigned N_SER = 4;

  logic [N_SER-1:0]  ser_s;
  logic [CTRL_W-1:0] ctrl_w;
  logic              load_w, multi_w, pwr_dn_w;
  logic              err_q;
  tap_sel_t          sel_w;

  pll_enh_sync #(.WIDTH(N_SER), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sen_i, swr_i, sclk_i, sdata_i}),
    .q_o   (ser_s)
  );

  pll_enh_sif i_sif (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sdata_i(ser_s[0]),
    .sclk_i (ser_s[1]),
    .swr_i  (ser_s[2]),
    .sen_i  (ser_s[3]),
    .ctrl_o (ctrl_w),
    .load_o (load_w)
  );

  assign sel_w    = '{rf: ctrl_w[B_TAP_RF], ms: ctrl_w[B_TAP_MS], fb: ctrl_w[B_TAP_FB]};
  assign pwr_dn_w = ctrl_w[B_PWR];

  pll_enh_tap i_tap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_w),
    .pwr_dn_i(pwr_dn_w),
    .fb_i    (fb_div_i),
    .ms_i    (mod_sel_i),
    .rf_i    (ref_div_i),
    .tap_o   (test_o),
    .multi_o (multi_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (multi_w) err_q <= 1'b1;
  end

  assign pwr_dn_o     = pwr_dn_w;
  assign cnt_load_o   = ctrl_w[B_LOAD] & ~pwr_dn_w;
  assign pre_bypass_o = ctrl_w[B_BYP];
  assign sel_err_o    = err_q;

  p_rsvd_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_w[B_RSV1:B_RSV0] == 2'b00);
  p_pd_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_o |-> (!test_o && !cnt_load_o));
  p_err_on_multi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_w |=> sel_err_o);
  p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_err_o |=> sel_err_o);
  p_load_only_strobe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_w |=> ($stable(pwr_dn_o) && $stable(pre_bypass_o)));
endmodule

// File: tb/test_pll_enh_ctrl.sv
`timescale 1ns/1ps
module test_pll_enh_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 0, sclk = 0, swr = 0, sen = 0;
  logic fb = 0, ms = 0, rf = 0;
  logic pwr_dn, cnt_load, bypass, tst, err;

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  bit settle = 1'b1;
  logic [7:0] m_reg = 8'h00;
  logic m_err = 1'b0;

  always #2.5 clk = ~clk;

  pll_enh_ctrl i_pll_enh_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .sclk_i(sclk),
    .swr_i(swr), .sen_i(sen), .fb_div_i(fb), .mod_sel_i(ms),
    .ref_div_i(rf), .pwr_dn_o(pwr_dn), .cnt_load_o(cnt_load),
    .pre_bypass_o(bypass), .test_o(tst), .sel_err_o(err)
  );

  task automatic chk(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  function automatic logic exp_tap();
    if (m_reg[3])      return 1'b0;
    else if (m_reg[2]) return fb;
    else if (m_reg[5]) return ms;
    else if (m_reg[6]) return rf;
    return 1'b0;
  endfunction

  function automatic string tap_tag();
    int n;
    n = int'(m_reg[2]) + int'(m_reg[5]) + int'(m_reg[6]);
    if (m_reg[3]) return "R10";
    if (n > 1)    return "R9";
    if (m_reg[2]) return "R5";
    if (m_reg[5]) return "R6";
    if (m_reg[6]) return "R7";
    return "R8";
  endfunction

  // source stimulus
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    fb = cyc[0];
    ms = cyc[1];
    rf = cyc[2] ^ cyc[0];
  end

  // reference comparison every clock
  always @(negedge clk) begin
    if (rst_n && !settle) begin
      chk("R2 pwr_dn", pwr_dn, m_reg[3]);
      chk("R2 cnt_load", cnt_load, m_reg[4] & ~m_reg[3]);
      chk("R2 bypass", bypass, m_reg[7]);
      chk(tap_tag(), tst, exp_tap());
      chk("R11 sel_err", err, m_err);
    end
  end

  task automatic hold(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_word(logic [7:0] w, logic en);
    int n;
    settle = 1'b1;
    sen = en;
    for (int i = 7; i >= 0; i--) begin
      sdata = w[i]; hold(3);
      sclk = 1'b1;  hold(3);
      sclk = 1'b0;  hold(3);
    end
    swr = 1'b1; hold(4);
    swr = 1'b0; hold(5);
    sen = 1'b0;
    if (en) begin
      m_reg = w & 8'hFC;
      n = int'(m_reg[2]) + int'(m_reg[5]) + int'(m_reg[6]);
      if (n > 1) m_err = 1'b1;
    end
    hold(2);
    settle = 1'b0;
  endtask

  task automatic shift_only(logic [7:0] w);
    sen = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sdata = w[i]; hold(2);
      sclk = 1'b1;  hold(2);
      sclk = 1'b0;  hold(2);
    end
    sen = 1'b0;
    hold(4);
  endtask

  task automatic snap(string tag, logic p, logic l, logic b, logic e);
    @(negedge clk);
    chk({tag, " pwr_dn"}, pwr_dn, p);
    chk({tag, " cnt_load"}, cnt_load, l);
    chk({tag, " bypass"}, bypass, b);
    chk({tag, " sel_err"}, err, e);
  endtask

  initial begin
    hold(1);
    snap("R1 reset", 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); chk("R1 test_o", tst, 1'b0);
    hold(2);
    rst_n = 1'b1;
    hold(2);
    settle = 1'b0;

    write_word(8'h80, 1'b1);          // MSB-first: only bypass
    snap("R2 msb", 1'b0, 1'b0, 1'b1, 1'b0);
    write_word(8'h90, 1'b1);
    snap("R2 load+byp", 1'b0, 1'b1, 1'b1, 1'b0);
    write_word(8'h04, 1'b1); hold(12); // R5
    write_word(8'h20, 1'b1); hold(12); // R6
    write_word(8'h40, 1'b1); hold(12); // R7
    write_word(8'h00, 1'b1); hold(8);  // R8
    write_word(8'hFF, 1'b0);          // R3 enable low
    snap("R3 no-en", 1'b0, 1'b0, 1'b0, 1'b0);
    write_word(8'h03, 1'b1);          // R4 reserved only
    snap("R4 rsvd", 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); chk("R4 test_o", tst, 1'b0);
    write_word(8'h86, 1'b1);          // R4 reserved with fb
    hold(8);
    shift_only(8'h08);                // R12
    snap("R12 shift", 1'b0, 1'b0, 1'b1, 1'b0);
    write_word(8'h1C, 1'b1);          // R10 pd with fb + load
    hold(8);
    snap("R10 pd", 1'b1, 1'b0, 1'b0, 1'b0);
    write_word(8'h14, 1'b1);          // R10 wake while powered down
    hold(8);
    snap("R10 wake", 1'b0, 1'b1, 1'b0, 1'b0);
    write_word(8'h64, 1'b1); hold(12); // R9 fb wins
    snap("R9 flag", 1'b0, 1'b0, 1'b0, 1'b1);
    write_word(8'h60, 1'b1); hold(12); // R9 ms wins
    write_word(8'h40, 1'b1); hold(8);  // R11 clean word
    snap("R11 sticky", 1'b0, 1'b0, 1'b0, 1'b1);

    settle = 1'b1;
    rst_n = 1'b0;
    hold(2);
    snap("R1 re-reset", 1'b0, 1'b0, 1'b0, 1'b0);
    m_reg = 8'h00; m_err = 1'b0;
    rst_n = 1'b1;
    hold(2);
    settle = 1'b0;
    hold(6);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule